// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port memory and watches both access ports. When both ports are enabled on the same address, it decides which one got there first. It lets that port carry on and pulls the other port's busy line low. While a port is held busy, its write strobe is suppressed, so it cannot corrupt the word the winner is using. Reads on a busy port are not gated here; only the write enable toward the array is qualified.

Arrival order is judged at clock granularity. Each port's chip enable and address are registered, so a port counts as newly arrived in a cycle when it has just become enabled or has just changed address. When the match first appears, the newly arrived port loses. If both ports arrive in the same cycle, the right port loses. The decision is held for as long as the match lasts. Busy is released in the very cycle the match goes away.

A parameter selects the configuration. In the master configuration the block drives the busy lines from its own arbitration. In the slave configuration the busy lines are taken from outside, passed through, and used only to block writes.

Top module: `dpa_collision_arbiter`

## Requirements
- R1: With both chip enables high and different addresses, or with either chip enable low, both busy outputs (active low) are 1.
- R2: When a match appears because the left port newly arrived (became enabled or changed address) while the right port's request was unchanged, left busy is 0 and right busy is 1 in that same cycle.
- R3: When a match appears because the right port newly arrived while the left port's request was unchanged, right busy is 0 and left busy is 1 in that same cycle.
- R4: When both ports newly arrive in the same cycle on a matching address, right busy is 0 and left busy is 1.
- R5: The two busy outputs are never 0 at the same time.
- R6: A port's gated write enable is 1 only when its chip enable and write request are both 1 and its busy is 1. A write on a busy port produces a gated write enable of 0.
- R7: Busy returns to 1 in the first cycle in which the address match ends or either chip enable drops.
- R8: While the match persists, the busy port stays the same, even if both addresses move together to a new common value or the write requests change.
- R9: In the slave configuration (IS_MASTER=0), each busy output equals its external busy input and gates that port's write enable as in R6. No internal arbitration takes place.
- R10: After reset, both busy outputs are 1. Both gated write enables are 0 while the chip enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_ce | input | 1 | Left chip enable, active high |
| l_addr | input | AW | Left address |
| l_we | input | 1 | Left write request |
| r_ce | input | 1 | Right chip enable, active high |
| r_addr | input | AW | Right address |
| r_we | input | 1 | Right write request |
| l_busy_in_n | input | 1 | External left busy, used in the slave configuration |
| r_busy_in_n | input | 1 | External right busy, used in the slave configuration |
| l_busy_n | output | 1 | Left busy, active low, push-pull |
| r_busy_n | output | 1 | Right busy, active low, push-pull |
| l_we_ok | output | 1 | Gated left write enable |
| r_we_ok | output | 1 | Gated right write enable |

## Verification
The hardest case to create is a match that persists while both addresses move together. A second case is a same-cycle arrival, which the tie rule resolves, as opposed to a staggered one. The stimulus reaches both on purpose. It first forces a same-cycle collision from idle. It then changes both addresses in one cycle while keeping them equal, and expects the earlier loser to stay busy. Staggered arrivals are created in both directions by holding one port steady while the other changes address onto it. A slave-configured instance receives the same inputs, with its external busy lines toggled independently, to show that only writes respond to them.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [1:0] {
    COLL_NONE        = 2'd0,
    COLL_LEFT_LOSES  = 2'd1,
    COLL_RIGHT_LOSES = 2'd2
  } coll_e;
endpackage

// File: rtl/dpa_port_tracker.sv
module dpa_port_tracker #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic [AW-1:0] addr,
  output logic          fresh
);
  logic          ce_q, ce_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          upd_en;

  // update only while a request is present or was present last cycle
  assign upd_en = ce | ce_q;

  always_comb begin
    ce_d   = ce;
    addr_d = ce ? addr : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q   <= 1'b0;
      addr_q <= '0;
    end else if (upd_en) begin
      ce_q   <= ce_d;
      addr_q <= addr_d;
    end
  end

  assign fresh = ce && (!ce_q || (addr != addr_q));

  // a request that just appeared is always fresh (R2/R3 basis)
  p_rise_is_fresh_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !ce_q) |-> fresh);
endmodule

// File: rtl/dpa_collision_fsm.sv
module dpa_collision_fsm
  import dpa_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_ce,
  input  logic [AW-1:0] l_addr,
  input  logic          l_fresh,
  input  logic          r_ce,
  input  logic [AW-1:0] r_addr,
  input  logic          r_fresh,
  output logic          l_busy,
  output logic          r_busy
);
  coll_e state_q, state_d;
  logic  match;

  assign match = l_ce && r_ce && (l_addr == r_addr);

  always_comb begin
    state_d = COLL_NONE;
    if (match) begin
      if (state_q != COLL_NONE)        state_d = state_q;
      else if (l_fresh && !r_fresh)    state_d = COLL_LEFT_LOSES;
      else                             state_d = COLL_RIGHT_LOSES;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= COLL_NONE;
    else        state_q <= state_d;
  end

  assign l_busy = (state_d == COLL_LEFT_LOSES);
  assign r_busy = (state_d == COLL_RIGHT_LOSES);

  p_busy_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_busy && r_busy));
  p_free_without_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !match |-> (!l_busy && !r_busy));
  p_tie_goes_right_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (match && l_fresh && r_fresh && state_q == COLL_NONE) |-> r_busy);
  p_left_loser_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    l_busy |=> (!match || l_busy));
  p_right_loser_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    r_busy |=> (!match || r_busy));
endmodule

// File: rtl/dpa_write_gate.sv
module dpa_write_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic we,
  input  logic busy_n,
  output logic we_ok
);
  assign we_ok = ce & we & busy_n;

  p_busy_blocks_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> !we_ok);
  p_idle_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |-> !we_ok);
endmodule

// File: rtl/dpa_collision_arbiter.sv
module dpa_collision_arbiter #(
  parameter int AW        = 16,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_ce,
  input  logic [AW-1:0] l_addr,
  input  logic          l_we,
  input  logic          r_ce,
  input  logic [AW-1:0] r_addr,
  input  logic          r_we,
  input  logic          l_busy_in_n,
  input  logic          r_busy_in_n,
  output logic          l_busy_n,
  output logic          r_busy_n,
  output logic          l_we_ok,
  output logic          r_we_ok
);
  localparam int NPORT = 2;

  logic [NPORT-1:0]         ce_v, we_v, fresh_v, busy_n_v, we_ok_v;
  logic [NPORT-1:0][AW-1:0] addr_v;
  logic                     l_busy_int, r_busy_int;

  assign ce_v   = {r_ce, l_ce};
  assign we_v   = {r_we, l_we};
  assign addr_v = {r_addr, l_addr};

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    dpa_port_tracker #(.AW(AW)) u_trk (
      .clk(clk), .rst_n(rst_n), .ce(ce_v[g]), .addr(addr_v[g]),
      .fresh(fresh_v[g]));
    dpa_write_gate u_gate (
      .clk(clk), .rst_n(rst_n), .ce(ce_v[g]), .we(we_v[g]),
      .busy_n(busy_n_v[g]), .we_ok(we_ok_v[g]));
  end

  dpa_collision_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .l_ce(l_ce), .l_addr(l_addr), .l_fresh(fresh_v[0]),
    .r_ce(r_ce), .r_addr(r_addr), .r_fresh(fresh_v[1]),
    .l_busy(l_busy_int), .r_busy(r_busy_int));

  if (IS_MASTER) begin : g_master
    logic unused_ext;
    assign unused_ext = l_busy_in_n ^ r_busy_in_n;
    assign busy_n_v   = {~r_busy_int, ~l_busy_int};
  end else begin : g_slave
    logic unused_int;
    assign unused_int = l_busy_int ^ r_busy_int;
    assign busy_n_v   = {r_busy_in_n, l_busy_in_n};
  end

  assign l_busy_n = busy_n_v[0];
  assign r_busy_n = busy_n_v[1];
  assign l_we_ok  = we_ok_v[0];
  assign r_we_ok  = we_ok_v[1];

  if (!IS_MASTER) begin : g_slave_chk
    p_slave_passthru_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (l_busy_n == l_busy_in_n) && (r_busy_n == r_busy_in_n));
  end
endmodule

// File: tb/dpa_collision_arbiter_test.sv
module dpa_collision_arbiter_test;
  localparam int AW = 16;

  typedef struct {
    logic lb, rb, lw, rw, slb, srb, slw, srw;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_ce = 0, l_we = 0, r_ce = 0, r_we = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic ext_l = 1, ext_r = 1;
  logic lb, rb, lw, rw, slb, srb, slw, srw;
  int checks = 0, failures = 0;
  exp_t q[$];
  bit done = 0;

  always #10 clk = ~clk;

  dpa_collision_arbiter #(.AW(AW), .IS_MASTER(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .l_ce(l_ce), .l_addr(l_addr), .l_we(l_we),
    .r_ce(r_ce), .r_addr(r_addr), .r_we(r_we),
    .l_busy_in_n(ext_l), .r_busy_in_n(ext_r),
    .l_busy_n(lb), .r_busy_n(rb), .l_we_ok(lw), .r_we_ok(rw));

  dpa_collision_arbiter #(.AW(AW), .IS_MASTER(1'b0)) uut_slave (
    .clk(clk), .rst_n(rst_n), .l_ce(l_ce), .l_addr(l_addr), .l_we(l_we),
    .r_ce(r_ce), .r_addr(r_addr), .r_we(r_we),
    .l_busy_in_n(ext_l), .r_busy_in_n(ext_r),
    .l_busy_n(slb), .r_busy_n(srb), .l_we_ok(slw), .r_we_ok(srw));

  task automatic cmp(string tag, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, nm, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected outputs
  task automatic step(input logic lce, input logic [AW-1:0] la, input logic lwe,
                      input logic rce, input logic [AW-1:0] ra, input logic rwe,
                      input logic sl, input logic sr,
                      input logic elb, input logic erb, input string tag);
    exp_t e;
    @(negedge clk);
    l_ce = lce; l_addr = la; l_we = lwe;
    r_ce = rce; r_addr = ra; r_we = rwe;
    ext_l = sl; ext_r = sr;
    e.lb = elb; e.rb = erb;
    e.lw = lce & lwe & elb;          // R6
    e.rw = rce & rwe & erb;
    e.slb = sl; e.srb = sr;          // R9
    e.slw = lce & lwe & sl;
    e.srw = rce & rwe & sr;
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares mid-cycle, away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.tag, "l_busy_n", lb, e.lb);
        cmp(e.tag, "r_busy_n", rb, e.rb);
        cmp(e.tag, "l_we_ok", lw, e.lw);
        cmp(e.tag, "r_we_ok", rw, e.rw);
        cmp({e.tag, "/R9"}, "slave l_busy_n", slb, e.slb);
        cmp({e.tag, "/R9"}, "slave r_busy_n", srb, e.srb);
        cmp({e.tag, "/R9"}, "slave l_we_ok", slw, e.slw);
        cmp({e.tag, "/R9"}, "slave r_we_ok", srw, e.srw);
      end
    end
  end

  initial begin
    #200_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step(0, 16'h0000, 0, 0, 16'h0000, 0, 1, 1, 1, 1, "R10 reset idle");
    step(1, 16'h0005, 1, 1, 16'h0009, 1, 1, 1, 1, 1, "R1 distinct addr");
    step(1, 16'h0005, 1, 1, 16'h0005, 1, 0, 1, 1, 0, "R3 right arrives late");
    step(1, 16'h0005, 1, 1, 16'h0005, 1, 1, 0, 1, 0, "R8 hold");
    step(1, 16'h0005, 1, 0, 16'h0005, 1, 1, 1, 1, 1, "R7 right ce drop");
    step(1, 16'h0005, 1, 1, 16'h0005, 1, 0, 0, 1, 0, "R3 right re-enables");
    step(1, 16'h0007, 1, 1, 16'h0005, 1, 1, 1, 1, 1, "R7 left moves away");
    step(1, 16'h0005, 1, 1, 16'h0005, 1, 1, 0, 0, 1, "R2 left arrives late");
    step(1, 16'h0005, 0, 1, 16'h0005, 1, 0, 1, 0, 1, "R8 we change keeps loser");
    step(0, 16'h0005, 1, 0, 16'h0005, 1, 1, 1, 1, 1, "R1 both disabled");
    step(1, 16'h0003, 1, 1, 16'h0003, 1, 1, 1, 1, 0, "R4 same-cycle arrival");
    step(1, 16'h000A, 1, 1, 16'h000A, 1, 1, 0, 1, 0, "R8 joint move");
    step(0, 16'h000A, 1, 1, 16'h000A, 1, 0, 1, 1, 1, "R7 left ce drop");
    step(1, 16'h000A, 1, 1, 16'h000A, 1, 1, 1, 0, 1, "R2 left re-enables");
    step(1, 16'h000A, 1, 1, 16'h000B, 1, 1, 1, 1, 1, "R7 right moves away");
    step(1, 16'hFFFF, 1, 1, 16'hFFFF, 1, 1, 1, 1, 0, "R4 top address tie");
    step(1, 16'hFFFF, 1, 1, 16'hFFFF, 1, 0, 0, 1, 0, "R5 single busy");
    step(0, 16'h0000, 0, 0, 16'h0000, 0, 1, 1, 1, 1, "R10 idle again");
    wait (q.size() == 0);
    @(negedge clk); #8;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule